// File: doc/BRIEF.md
# Windowed Program Bank Mapper

This block sits between an 8-bit CPU bus and an external program ROM that is larger than the CPU can address. It divides the upper 32 KiB of the CPU address space, where A15 is high, into four 8 KiB windows and gives each window its own bank register. Bits A14:A13 of the CPU address pick one window. That choice decides which register a write loads and which register drives the ROM's upper address lines.

Software changes the mapping by writing a bank number anywhere inside a window. The block takes the write on the falling edge of the bus-cycle strobe while R/W is low. The ROM has no writable cells, so its output-enable stays off during those writes and does not drive the data bus. On reads, the selected register supplies ROM address bits 18:13 and CPU bits 12:0 pass through unchanged. After reset, the last window holds the highest bank and the other windows hold bank 0, so the reset vector comes from a known place.

Top module: `wbm_mapper`

## Requirements
- R1: When a read falls in a window (A15 = 1), bits 18:13 of rom_addr equal the bank register of the window that cpu_addr[14:13] selects. Value 0 selects window $8000, 1 selects $A000, 2 selects $C000 and 3 selects $E000.
- R2: rom_addr[12:0] always equals cpu_addr[12:0].
- R3: A write loads one bank register. The conditions are cpu_rw = 0, cpu_addr[15] = 1, and cpu_strobe sampled high at one clock edge and low at the next. At that second edge, cpu_data[5:0] goes into the register of window cpu_addr[14:13]. It shows on rom_addr from then on.
- R4: A strobe falling edge with cpu_rw = 0 and cpu_addr[15] = 0 leaves all four bank registers unchanged.
- R5: Without a strobe falling edge, no register changes. This holds while cpu_rw = 0 with the strobe held high or held low.
- R6: rom_oe is 1 exactly when cpu_addr[15] = 1 and cpu_rw = 1, and 0 otherwise.
- R7: After reset, window 3 holds bank 63 and windows 0, 1 and 2 hold bank 0.
- R8: cpu_data[7:6] have no effect on the stored bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the bus strobe is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_strobe | input | 1 | Bus-cycle strobe; a write is taken on its falling edge |
| rom_addr | output | 19 | Extended ROM address: bank number above the 13 offset bits |
| rom_oe | output | 1 | ROM output-enable, active high |

## Verification
The assertions assume that cpu_addr, cpu_data and cpu_rw are synchronous to clk and stay steady across the clock edge where the strobe is first seen low. They also assume each strobe pulse lasts at least one clock in each level. The bench changes every input only on the falling clock edge and holds address, data and R/W for two clocks around each strobe fall. Its random writes and reads therefore always meet these assumptions. The directed cases cover a strobe held low or high while R/W is low, writes with A15 low, and data with the top two bits set.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  localparam int unsigned CPU_AW_DEF   = 16;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned WIN_BITS_DEF = 2;
  localparam int unsigned BANK_W_DEF   = 6;

  // Reset bank for a window: the last window holds the top bank so the
  // vector area maps to a fixed place, the rest start at bank 0.
  function automatic logic [31:0] reset_bank(input int unsigned win,
                                             input int unsigned nwin,
                                             input int unsigned bw);
    logic [31:0] r;
    r = '0;
    if (win == nwin - 1) r = (32'd1 << bw) - 32'd1;
    return r;
  endfunction
endpackage

// File: rtl/wbm_reset_sync.sv
module wbm_reset_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wbm_strobe_edge.sv
module wbm_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;
  logic strobe_d;

  always_comb strobe_d = strobe_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_d;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/wbm_bank_file.sv
module wbm_bank_file
  import wbm_pkg::*;
#(
  parameter int unsigned WIN_BITS = WIN_BITS_DEF,
  parameter int unsigned BANK_W   = BANK_W_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  localparam int unsigned NWIN    = 1 << WIN_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [WIN_BITS-1:0]      sel_i,
  input  logic [DATA_W-1:0]        din_i,
  output logic [NWIN*BANK_W-1:0]   banks_o
);
  logic [BANK_W-1:0] wr_val;
  logic              unused_hi;

  assign wr_val    = din_i[BANK_W-1:0];
  assign unused_hi = ^din_i[DATA_W-1:BANK_W];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [BANK_W-1:0] RST_VAL = BANK_W'(reset_bank(w, NWIN, BANK_W));
    logic              en;
    logic [BANK_W-1:0] q;
    logic [BANK_W-1:0] d;

    assign en = we_i && (sel_i == WIN_BITS'(w));

    always_comb begin
      d = q;
      if (en) d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
    end

    assign banks_o[w*BANK_W +: BANK_W] = q;

    // R3 / R8: a write to this window stores the low data bits
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && sel_i == WIN_BITS'(w)) |=> (q == $past(din_i[BANK_W-1:0])));
  end

  // R5: no write strobe, no change anywhere in the file
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(banks_o));
endmodule

// File: rtl/wbm_window_mux.sv
module wbm_window_mux
  import wbm_pkg::*;
#(
  parameter int unsigned WIN_BITS = WIN_BITS_DEF,
  parameter int unsigned BANK_W   = BANK_W_DEF,
  localparam int unsigned NWIN    = 1 << WIN_BITS
) (
  input  logic [NWIN*BANK_W-1:0] banks_i,
  input  logic [WIN_BITS-1:0]    sel_i,
  output logic [BANK_W-1:0]      bank_o
);
  always_comb begin
    bank_o = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (sel_i == WIN_BITS'(w)) bank_o = banks_i[w*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/wbm_mapper.sv
module wbm_mapper
  import wbm_pkg::*;
#(
  parameter int unsigned CPU_AW   = CPU_AW_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned WIN_BITS = WIN_BITS_DEF,
  parameter int unsigned BANK_W   = BANK_W_DEF,
  localparam int unsigned OFF_W   = CPU_AW - 1 - WIN_BITS,
  localparam int unsigned NWIN    = 1 << WIN_BITS,
  localparam int unsigned ROM_AW  = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_rw,
  input  logic              cpu_strobe,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_oe
);
  logic                   rst_sync_n;
  logic                   strobe_fall;
  logic                   hi_region;
  logic                   wr_en;
  logic [WIN_BITS-1:0]    win_sel;
  logic [NWIN*BANK_W-1:0] banks;
  logic [BANK_W-1:0]      cur_bank;

  assign hi_region = cpu_addr[CPU_AW-1];
  assign win_sel   = cpu_addr[CPU_AW-2 -: WIN_BITS];
  assign wr_en     = strobe_fall & ~cpu_rw & hi_region;

  wbm_reset_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  wbm_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe_i (cpu_strobe),
    .fall_o   (strobe_fall)
  );

  wbm_bank_file #(
    .WIN_BITS (WIN_BITS),
    .BANK_W   (BANK_W),
    .DATA_W   (DATA_W)
  ) u_banks (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (wr_en),
    .sel_i   (win_sel),
    .din_i   (cpu_data),
    .banks_o (banks)
  );

  wbm_window_mux #(
    .WIN_BITS (WIN_BITS),
    .BANK_W   (BANK_W)
  ) u_mux (
    .banks_i (banks),
    .sel_i   (win_sel),
    .bank_o  (cur_bank)
  );

  assign rom_addr = {cur_bank, cpu_addr[OFF_W-1:0]};
  assign rom_oe   = hi_region & cpu_rw;

  // R4: a strobe fall with A15 low must not alter the banks
  p_lowhold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_fall && !hi_region) |=> $stable(banks));

  // R6: the ROM never drives while the CPU writes
  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cpu_rw |-> !rom_oe);
endmodule

// File: tb/wbm_mapper_bench.sv
module wbm_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        cpu_rw;
  logic        cpu_strobe;
  logic [18:0] rom_addr;
  logic        rom_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [5:0] exp_bank [4];

  always #2 clk = ~clk;

  wbm_mapper u_wbm_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .cpu_strobe(cpu_strobe), .rom_addr(rom_addr), .rom_oe(rom_oe)
  );

  function automatic logic [18:0] exp_rom(input logic [15:0] a);
    return {exp_bank[a[14:13]], a[12:0]};
  endfunction

  function automatic logic exp_oe(input logic [15:0] a, input logic rw);
    return a[15] & rw;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [15:0] a, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_rw = 1'b1; cpu_strobe = 1'b1;
    #1;
    check(req, 32'(rom_addr), 32'(exp_rom(a)));
    check("R6", 32'(rom_oe), 32'(exp_oe(a, 1'b1)));
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; cpu_strobe = 1'b1;
    #1 check("R6", 32'(rom_oe), 32'd0);
    @(negedge clk);
    cpu_strobe = 1'b0;
    @(negedge clk);
    cpu_strobe = 1'b1; cpu_rw = 1'b1;
    if (a[15]) exp_bank[a[14:13]] = d[5:0];
  endtask

  task automatic all_windows(input string req);
    for (int w = 0; w < 4; w++) begin
      logic [15:0] a;
      a = {1'b1, 2'(w), 13'($urandom)};
      read_chk(a, req);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; cpu_addr = '0; cpu_data = '0; cpu_rw = 1'b1; cpu_strobe = 1'b1;
    exp_bank[0] = 6'd0; exp_bank[1] = 6'd0; exp_bank[2] = 6'd0; exp_bank[3] = 6'd63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state, R1/R2 through the read path
    all_windows("R7");
    read_chk(16'hFFFC, "R7");

    // R6: A15 low read leaves ROM disabled
    @(negedge clk); cpu_addr = 16'h4123; cpu_rw = 1'b1; #1;
    check("R6", 32'(rom_oe), 32'd0);
    check("R2", 32'(rom_addr[12:0]), 32'h0123);

    // R3 directed: distinct bank per window
    cpu_write(16'h8000, 8'd5);
    cpu_write(16'hA7FF, 8'd17);
    cpu_write(16'hDFFF, 8'd42);
    cpu_write(16'hE001, 8'd9);
    all_windows("R3");

    // R8: upper data bits ignored
    cpu_write(16'hC100, 8'hFF);
    read_chk(16'hC000, "R8");
    check("R8", 32'(rom_addr[18:13]), 32'd63);
    cpu_write(16'h9000, 8'hC4);
    read_chk(16'h8ABC, "R8");
    check("R8", 32'(rom_addr[18:13]), 32'd4);

    // R4: writes below A15 change nothing
    cpu_write(16'h6000, 8'd33);
    cpu_write(16'h0000, 8'd21);
    all_windows("R4");

    // R5: strobe held low across a write-direction phase
    @(negedge clk); cpu_strobe = 1'b0; cpu_rw = 1'b1; cpu_addr = 16'hA000;
    @(negedge clk); cpu_rw = 1'b0; cpu_data = 8'd50;
    repeat (3) @(negedge clk);
    cpu_data = 8'd51;
    @(negedge clk); cpu_rw = 1'b1; cpu_strobe = 1'b1;
    all_windows("R5");
    // R5: strobe held high with R/W low
    @(negedge clk); cpu_addr = 16'hE000; cpu_rw = 1'b0; cpu_data = 8'd60;
    repeat (4) @(negedge clk);
    cpu_rw = 1'b1;
    all_windows("R5");

    // Random writes and reads
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 4 != 0) a[15] = 1'b1;
      cpu_write(a, 8'($urandom));
      read_chk({1'b1, 15'($urandom)}, "R1");
    end
    all_windows("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule